// File: doc/BRIEF.md
# Multi-drop receiver sleep and wake-up controller

This block decides whether a serial receiver on a shared multi-drop line is asleep. Software writes a sleep request when a message on the line is not meant for this node. From then on the block holds a flag-inhibit output high, so the receive-complete flag and its interrupt are kept from software. The block then watches for a wake condition. When the condition is met, it clears the sleep bit in hardware and raises a one-cycle wake strobe.

There are two wake methods, and a single select bit chooses one of them. In idle-line mode, the block counts bit-period samples of the receive line. It wakes once a full character time of consecutive ones has been seen: ten samples with 8-bit data, eleven with 9-bit data. In address-mark mode, it wakes on a completed character whose top data bit is one. That address character is passed through with its flag, so software can compare the address and, if it does not match, put the receiver back to sleep. Recovering bits and checking framing are done outside this block. It receives a bit-period tick, the sampled line level, and a character-complete strobe together with the received word.

Top module: `rxw_wake_ctrl`

## Requirements
- R1: After reset, sleep_q, flag_inhibit and wake_clear are all 0.
- R2: When sleep_req is high at a clock edge and no wake occurs in that cycle, sleep_q is 1 after that edge. While sleep_q is 1, flag_inhibit is 1, except in the case given by R6.
- R3: With wake_sel=0 and nine_bit=0, a sleeping receiver wakes on the tenth consecutive bit_tick cycle that samples rx_line=1. In that cycle wake_clear is 1, and sleep_q is 0 after the edge.
- R4: With wake_sel=0 and nine_bit=1, eleven consecutive one-samples are needed to wake.
- R5: A bit_tick sample with rx_line=0 restarts the idle count from zero. Cycles without bit_tick neither add to the count nor reset it. The count never goes above the threshold.
- R6: With wake_sel=1, a char_done strobe while asleep wakes the receiver if the mark bit is 1. The mark bit is char_word[7] when nine_bit=0 and char_word[8] when nine_bit=1. In that cycle flag_inhibit is 0, so the address character is delivered, and wake_clear is 1.
- R7: With wake_sel=1, characters whose mark bit is 0 do not wake the receiver and stay inhibited. Any length of idle ones does not wake the receiver either.
- R8: With wake_sel=0, a character with its mark bit set does not wake the receiver.
- R9: While sleep_q is 0, flag_inhibit and wake_clear are both 0, whatever the line and the characters do.
- R10: If a wake condition and sleep_req happen in the same cycle, the wake wins and sleep_q is 0 after the edge.
- R11: The idle count is held at zero while awake. After a new sleep request, a full threshold of one-samples is needed, even if the line was already idle before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Receive line level, sampled on bit_tick |
| bit_tick | input | 1 | One-cycle pulse per bit period at the bit centre |
| char_done | input | 1 | One-cycle strobe when a character has been received |
| char_word | input | 9 | Received character; bit 8 is used only in 9-bit mode |
| nine_bit | input | 1 | Data-length mode: 0 = 8 data bits, 1 = 9 data bits |
| wake_sel | input | 1 | Wake method: 0 = idle line, 1 = address mark |
| sleep_req | input | 1 | Software request to put the receiver to sleep |
| sleep_q | output | 1 | Current sleep bit; cleared by hardware on wake |
| flag_inhibit | output | 1 | High while receive flags and interrupts must be suppressed |
| wake_clear | output | 1 | One-cycle strobe when a wake clears the sleep bit |

## Verification
The bench targets an idle count that is off by one, and it does so in both data-length modes. A design with this fault wakes one sample early or late. It also interleaves cycles without a tick and one-sample breaks in the idle run. A design that counts every clock, or that fails to restart on a zero, then wakes during a message. The bench also checks:
- that a sleep request made on an already idle line still needs a full fresh count;
- that the mark bit is taken from the correct position in each mode;
- that the waking address character is not inhibited;
- that each method ignores the other method's wake condition.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_MARK = 1'b1
  } wake_method_e;

  // Number of consecutive one-samples that form an idle character.
  // Start bit + data bits (+ ninth bit) + stop bit.
  function automatic int unsigned idle_need(int unsigned data_bits, logic nine);
    return data_bits + 2 + (nine ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxw_idle_count.sv
module rxw_idle_count #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned MAX_NEED = DATA_BITS + 3,
  localparam int unsigned CNT_W = $clog2(MAX_NEED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             rx,
  input  logic             nine,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] need,
  output logic             hit
);
  import rxw_pkg::*;

  logic [CNT_W:0] cnt_inc;

  assign need    = CNT_W'(idle_need(DATA_BITS, nine));
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign hit     = enable & tick & rx & (cnt_inc >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rx) begin
        cnt <= '0;
      end else if (cnt_inc >= {1'b0, need}) begin
        cnt <= need;
      end else begin
        cnt <= cnt_inc[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rxw_mark_detect.sv
module rxw_mark_detect #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned WORD_W = DATA_BITS + 1
) (
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              nine,
  output logic              hit
);
  logic mark;

  assign mark = nine ? word[DATA_BITS] : word[DATA_BITS-1];
  assign hit  = done & mark;

endmodule

// File: rtl/rxw_sleep_reg.sv
module rxw_sleep_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wake,
  output logic sleep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep <= 1'b0;
    end else if (wake) begin
      sleep <= 1'b0;
    end else if (req) begin
      sleep <= 1'b1;
    end
  end

endmodule

// File: rtl/rxw_wake_ctrl.sv
module rxw_wake_ctrl #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned WORD_W = DATA_BITS + 1,
  localparam int unsigned CNT_W = $clog2(DATA_BITS + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              char_done,
  input  logic [WORD_W-1:0] char_word,
  input  logic              nine_bit,
  input  logic              wake_sel,
  input  logic              sleep_req,
  output logic              sleep_q,
  output logic              flag_inhibit,
  output logic              wake_clear
);
  import rxw_pkg::*;

  wake_method_e     method;
  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] idle_need_w;
  logic             idle_hit;
  logic             mark_hit;
  logic             wake_evt;

  assign method = wake_method_e'(wake_sel);

  rxw_idle_count #(.DATA_BITS(DATA_BITS)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(sleep_q),
    .tick  (bit_tick),
    .rx    (rx_line),
    .nine  (nine_bit),
    .cnt   (idle_cnt),
    .need  (idle_need_w),
    .hit   (idle_hit)
  );

  rxw_mark_detect #(.DATA_BITS(DATA_BITS)) u_mark (
    .done(char_done),
    .word(char_word),
    .nine(nine_bit),
    .hit (mark_hit)
  );

  assign wake_evt = sleep_q & ((method == WAKE_MARK) ? mark_hit : idle_hit);

  rxw_sleep_reg u_sleep (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (sleep_req),
    .wake (wake_evt),
    .sleep(sleep_q)
  );

  assign wake_clear   = wake_evt;
  assign flag_inhibit = sleep_q & ~((method == WAKE_MARK) & mark_hit);

endmodule

// File: rtl/rxw_wake_chk.sv
module rxw_wake_chk #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned CNT_W = $clog2(DATA_BITS + 4)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_line,
  input logic             bit_tick,
  input logic             char_done,
  input logic             wake_sel,
  input logic             sleep_req,
  input logic             sleep_q,
  input logic             flag_inhibit,
  input logic             wake_clear,
  input logic [CNT_W-1:0] idle_cnt,
  input logic [CNT_W-1:0] idle_need_w,
  input logic             idle_hit,
  input logic             mark_hit
);

  assert_awake_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |-> (!flag_inhibit && !wake_clear));

  assert_wake_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clear |=> !sleep_q);

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !wake_clear) |=> sleep_q);

  assert_mark_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && wake_sel && char_done && mark_hit) |-> (wake_clear && !flag_inhibit));

  assert_mark_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sel && wake_clear) |-> mark_hit);

  assert_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_sel && wake_clear) |-> idle_hit);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= idle_need_w);

  assert_zero_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_line) |=> (idle_cnt == '0));

  assert_awake_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |=> (idle_cnt == '0));

endmodule

bind rxw_wake_ctrl rxw_wake_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_line     (rx_line),
  .bit_tick    (bit_tick),
  .char_done   (char_done),
  .wake_sel    (wake_sel),
  .sleep_req   (sleep_req),
  .sleep_q     (sleep_q),
  .flag_inhibit(flag_inhibit),
  .wake_clear  (wake_clear),
  .idle_cnt    (idle_cnt),
  .idle_need_w (idle_need_w),
  .idle_hit    (idle_hit),
  .mark_hit    (mark_hit)
);

// File: tb/rxw_wake_ctrl_tb.sv
`timescale 1ns/1ps
module rxw_wake_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       bit_tick = 1'b0;
  logic       char_done = 1'b0;
  logic [8:0] char_word = '0;
  logic       nine_bit = 1'b0;
  logic       wake_sel = 1'b0;
  logic       sleep_req = 1'b0;
  logic       sleep_q, flag_inhibit, wake_clear;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  int exp_sleep = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  rxw_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .char_done(char_done), .char_word(char_word), .nine_bit(nine_bit),
    .wake_sel(wake_sel), .sleep_req(sleep_req), .sleep_q(sleep_q),
    .flag_inhibit(flag_inhibit), .wake_clear(wake_clear)
  );

  function automatic int need_of(bit nine);
    if (nine) return 11;
    return 10;
  endfunction

  function automatic bit mark_of(logic [8:0] w, bit nine);
    if (nine) return w[8];
    return w[7];
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit rx, bit tk, bit dn, logic [8:0] w, bit nine, bit sel, bit req,
                      string tag);
    int  e_wake, e_inh, hit_i, hit_m;
    rx_line = rx; bit_tick = tk; char_done = dn; char_word = w;
    nine_bit = nine; wake_sel = sel; sleep_req = req;
    #1;
    hit_i = (exp_sleep == 1 && tk && rx && exp_cnt + 1 >= need_of(nine)) ? 1 : 0;
    hit_m = (exp_sleep == 1 && dn && mark_of(w, nine)) ? 1 : 0;
    e_wake = sel ? hit_m : hit_i;
    e_inh = (exp_sleep == 1 && !(sel && hit_m)) ? 1 : 0;
    vectors++;
    cmp(tag, "sleep_q", int'(sleep_q), exp_sleep);
    cmp(tag, "flag_inhibit", int'(flag_inhibit), e_inh);
    cmp(tag, "wake_clear", int'(wake_clear), e_wake);
    @(posedge clk);
    if (exp_sleep == 0) exp_cnt = 0;
    else if (tk) exp_cnt = rx ? ((exp_cnt + 1 > need_of(nine)) ? need_of(nine) : exp_cnt + 1) : 0;
    if (e_wake == 1) exp_sleep = 0;
    else if (req) exp_sleep = 1;
    @(negedge clk);
  endtask

  task automatic ones(int n, bit nine, bit sel, string tag);
    for (int i = 0; i < n; i++) begin
      step(1, 1, 0, 9'h000, nine, sel, 0, tag);
      step(1, 0, 0, 9'h000, nine, sel, 0, tag);
    end
  endtask

  task automatic go_sleep(bit nine, bit sel, string tag);
    step(1, 0, 0, 9'h000, nine, sel, 1, tag);
    cmp(tag, "sleep after request", int'(sleep_q), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step(1, 0, 0, 9'h000, 0, 0, 0, "R1");
    // R2: sleep request, inhibit while asleep
    go_sleep(0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 9'h012, 0, 0, 0, "R2");
    // R3: ten ones in 8-bit idle mode
    ones(9, 0, 0, "R3");
    cmp("R3", "asleep after nine ones", int'(sleep_q), 1);
    ones(1, 0, 0, "R3");
    cmp("R3", "awake after ten ones", int'(sleep_q), 0);
    // R11: idle line before request does not count
    ones(12, 0, 0, "R11");
    go_sleep(0, 0, "R11");
    ones(9, 0, 0, "R11");
    cmp("R11", "fresh count still asleep", int'(sleep_q), 1);
    ones(1, 0, 0, "R11");
    // R5: zero restarts, gaps do not count
    go_sleep(0, 0, "R5");
    ones(7, 0, 0, "R5");
    step(0, 1, 0, 9'h000, 0, 0, 0, "R5");
    ones(9, 0, 0, "R5");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 9'h000, 0, 0, 0, "R5");
    cmp("R5", "gaps no wake", int'(sleep_q), 1);
    ones(1, 0, 0, "R5");
    cmp("R5", "wake after restart", int'(sleep_q), 0);
    // R4: eleven ones in 9-bit mode
    go_sleep(1, 0, "R4");
    ones(10, 1, 0, "R4");
    cmp("R4", "asleep after ten ones", int'(sleep_q), 1);
    ones(1, 1, 0, "R4");
    cmp("R4", "awake after eleven", int'(sleep_q), 0);
    // R8: mark chars ignored in idle mode
    go_sleep(0, 0, "R8");
    step(1, 0, 1, 9'h1FF, 0, 0, 0, "R8");
    step(1, 0, 1, 9'h180, 1, 0, 0, "R8");
    cmp("R8", "still asleep", int'(sleep_q), 1);
    ones(10, 0, 0, "R8");
    // R7: mark mode ignores idle and clear-mark chars
    go_sleep(0, 1, "R7");
    ones(25, 0, 1, "R7");
    step(1, 0, 1, 9'h07F, 0, 1, 0, "R7");
    step(1, 0, 1, 9'h0FF, 1, 1, 0, "R7");
    cmp("R7", "still asleep", int'(sleep_q), 1);
    // R6: mark wakes, bit 7 in 8-bit mode, bit 8 in 9-bit mode
    step(1, 0, 1, 9'h080, 0, 1, 0, "R6");
    cmp("R6", "awake after mark", int'(sleep_q), 0);
    go_sleep(1, 1, "R6");
    step(1, 0, 1, 9'h100, 1, 1, 0, "R6");
    cmp("R6", "awake after 9-bit mark", int'(sleep_q), 0);
    // R9: awake ignores everything
    ones(12, 0, 0, "R9");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 9'h1FF, i[0], i[1], 0, "R9");
    // R10: wake beats simultaneous request
    go_sleep(0, 1, "R10");
    step(1, 0, 1, 9'h080, 0, 1, 1, "R10");
    cmp("R10", "wake wins", int'(sleep_q), 0);
    // R2 random mix against the bench model
    for (int i = 0; i < 4000; i++) begin
      bit r_rx, r_tk, r_dn, r_nine, r_sel, r_req;
      logic [8:0] r_w;
      r_rx = ($urandom_range(0, 19) != 0);
      r_tk = ($urandom_range(0, 2) == 0);
      r_dn = ($urandom_range(0, 9) == 0);
      r_w = 9'($urandom);
      r_nine = ((i / 500) % 2) == 1;
      r_sel = ((i / 1000) % 2) == 1;
      r_req = ($urandom_range(0, 39) == 0);
      step(r_rx, r_tk, r_dn, r_w, r_nine, r_sel, r_req, "R2");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule